// File: doc/BRIEF.md
# Row-Column Addressed Static Memory

This block is a synthesizable behavioural model of a static memory whose storage is laid out the way a dense array is built. Each physical row holds several words, and the bits are interleaved: bit 0 of every word in the row sits together, then bit 1 of every word, and so on. An address arrives with two active-low controls, a block enable and a write enable. On a clock edge where the block is enabled, a latch register captures the address, the operation and the write data. On the following edge the operation is carried out.

The captured address is presented to the decoders as true and complemented bits. The upper part of the address drives a row decoder, which raises exactly one word line. The lower part picks one word out of that row. On a read it does this through a per-bit-position multiplexer, and on a write through a per-bit-position demultiplexer. A column index that points past the last word of a row is treated as out of range: a read returns zero and a write does nothing. The read data output changes only when a read completes.

Top module: `sram_rowcol_array`

## Requirements
- R1: A synchronous active-high reset clears the read data output and every stored word to zero.
- R2: When `en_n` is high at a clock edge, no operation is captured. No stored word changes, whatever `we_n`, `addr` and `wdata` carry.
- R3: When `en_n` is low and `we_n` is low at a clock edge, `wdata` is written to the addressed word on the next edge. A read of that word captured on that next edge returns the new value.
- R4: The low COL_BITS bits of `addr` are the column index and the remaining upper ROW_BITS bits are the row index (COL_BITS = ceil(log2 WORDS_PER_ROW)). A write changes only the word at that row and column.
- R5: A read is captured when `en_n` is low and `we_n` is high at edge t. Its data appears on `rdata` just after edge t+1. Just after edge t, `rdata` still shows its earlier value.
- R6: A column index equal to or greater than WORDS_PER_ROW is out of range. A read of it returns zero, and a write to it changes no stored word.
- R7: `rdata` keeps its value on every edge that does not complete a read, including while the block is disabled and while writes complete.
- R8: An operation captured at one edge completes at the next edge even when `en_n` is high at that next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Block enable, active low |
| we_n | input | 1 | Write enable, active low; high selects a read |
| addr | input | ROW_BITS+COL_BITS | Word address, row bits above column bits |
| wdata | input | WORD_W | Data to write |
| rdata | output | WORD_W | Data of the last completed read |

## Verification
Sweeping reads over the whole address space right after reset tells apart a correct reset from one that leaves stale contents. The same sweep shows whether out-of-range columns return zero. A write to every in-range address with data that depends on the address, followed by a full read-back, exposes any wrong row/column split or any word-line or column-select decode that touches neighbouring words. Back-to-back write-then-read pairs and read-then-disabled pairs pin down the one-edge latency and show that a captured operation completes on its own. Runs of disabled cycles and out-of-range writes, each followed by a fresh read-back, show that nothing leaked into storage and that the read data output held its value.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;

    localparam int DEF_WORD_W        = 8;
    localparam int DEF_ROW_BITS      = 3;
    localparam int DEF_WORDS_PER_ROW = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Both controls are active low.
    function automatic op_e decode_op(input logic en_n, input logic we_n);
        if (en_n) return OP_IDLE;
        return we_n ? OP_READ : OP_WRITE;
    endfunction

    // Number of column bits for a row of k words (at least one).
    function automatic int col_bits_for(input int k);
        return (k < 2) ? 1 : $clog2(k);
    endfunction

endpackage

// File: rtl/sram_rc_addr_latch.sv
module sram_rc_addr_latch
    import sram_rc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_t,
    output logic [ADDR_W-1:0] addr_c,
    output logic [WORD_W-1:0] wdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            addr_t  <= '0;
            addr_c  <= '1;
            wdata_q <= '0;
        end else begin
            op_q <= decode_op(~capture_en, we_n);
            if (capture_en) begin
                addr_t  <= addr;
                addr_c  <= ~addr;
                wdata_q <= wdata;
            end
        end
    end

    assert_latch_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !capture_en |=> (op_q == OP_IDLE) && $stable(addr_t))
        else $error("address latch moved while disabled");

endmodule

// File: rtl/sram_rc_row_decoder.sv
module sram_rc_row_decoder #(
    parameter int ROW_BITS = 3,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic [ROW_BITS-1:0] row_t,
    input  logic [ROW_BITS-1:0] row_c,
    output logic [ROWS-1:0]     wl
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        always_comb begin
            hit = fire;
            for (int b = 0; b < ROW_BITS; b++) begin
                hit = hit & (((r >> b) & 1) != 0 ? row_t[b] : row_c[b]);
            end
        end
        assign wl[r] = hit;
    end

    assert_one_wordline_R4: assert property (@(posedge clk) disable iff (rst)
        fire |-> $onehot(wl))
        else $error("active operation without a single word line");

    assert_wordlines_low_R2: assert property (@(posedge clk) disable iff (rst)
        !fire |-> (wl == '0))
        else $error("word line raised with no operation");

endmodule

// File: rtl/sram_rc_col_select.sv
module sram_rc_col_select #(
    parameter int WORD_W   = 8,
    parameter int K        = 3,
    parameter int COL_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [COL_BITS-1:0]       col_t,
    input  logic [COL_BITS-1:0]       col_c,
    input  logic [WORD_W-1:0][K-1:0]  row_bits,
    output logic [K-1:0]              col_sel,
    output logic                      in_range,
    output logic [WORD_W-1:0]         rd_word
);

    // Column decode from true/complement bits; no output for indices >= K.
    for (genvar j = 0; j < K; j++) begin : g_col
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int b = 0; b < COL_BITS; b++) begin
                hit = hit & (((j >> b) & 1) != 0 ? col_t[b] : col_c[b]);
            end
        end
        assign col_sel[j] = hit;
    end

    assign in_range = ({1'b0, col_t} < (COL_BITS+1)'(K));

    // Read multiplexer: one AND-OR per bit position across the k words.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign rd_word[b] = |(row_bits[b] & col_sel);
    end

    assert_range_guard_R6: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> (col_sel == '0))
        else $error("out-of-range column selected a word");

    assert_col_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        in_range |-> $onehot(col_sel))
        else $error("in-range column without a single select");

endmodule

// File: rtl/sram_rc_bit_array.sv
module sram_rc_bit_array #(
    parameter int WORD_W = 8,
    parameter int K      = 3,
    parameter int ROWS   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ROWS-1:0]          wl,
    input  logic [K-1:0]             col_sel,
    input  logic                     do_write,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0][K-1:0] row_q
);

    // Bit-interleaved storage: cells[row][bit][word].
    logic [WORD_W-1:0][K-1:0] cells [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[r] <= '0;
            end else if (wl[r] && do_write) begin
                for (int b = 0; b < WORD_W; b++) begin
                    for (int j = 0; j < K; j++) begin
                        if (col_sel[j]) cells[r][b][j] <= wdata[b];
                    end
                end
            end
        end

        assert_idle_row_holds_R4: assert property (@(posedge clk) disable iff (rst)
            !(wl[r] && do_write) |=> $stable(cells[r]))
            else $error("unselected row changed");
    end

    always_comb begin
        row_q = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (wl[r]) row_q = row_q | cells[r];
        end
    end

endmodule

// File: rtl/sram_rowcol_array.sv
module sram_rowcol_array
    import sram_rc_pkg::*;
#(
    parameter int WORD_W        = DEF_WORD_W,
    parameter int ROW_BITS      = DEF_ROW_BITS,
    parameter int WORDS_PER_ROW = DEF_WORDS_PER_ROW,
    localparam int COL_BITS     = col_bits_for(WORDS_PER_ROW),
    localparam int ADDR_W       = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int ROWS = 1 << ROW_BITS;

    op_e                                  op_q;
    logic [ADDR_W-1:0]                    addr_t;
    logic [ADDR_W-1:0]                    addr_c;
    logic [WORD_W-1:0]                    wdata_q;
    logic [ROWS-1:0]                      wl;
    logic [WORDS_PER_ROW-1:0]             col_sel;
    logic                                 in_range;
    logic [WORD_W-1:0]                    rd_word;
    logic [WORD_W-1:0][WORDS_PER_ROW-1:0] row_q;

    sram_rc_addr_latch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .capture_en (~en_n),
        .we_n       (we_n),
        .addr       (addr),
        .wdata      (wdata),
        .op_q       (op_q),
        .addr_t     (addr_t),
        .addr_c     (addr_c),
        .wdata_q    (wdata_q)
    );

    sram_rc_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
        .clk   (clk),
        .rst   (rst),
        .fire  (op_q != OP_IDLE),
        .row_t (addr_t[ADDR_W-1 -: ROW_BITS]),
        .row_c (addr_c[ADDR_W-1 -: ROW_BITS]),
        .wl    (wl)
    );

    sram_rc_bit_array #(.WORD_W(WORD_W), .K(WORDS_PER_ROW), .ROWS(ROWS)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wl       (wl),
        .col_sel  (col_sel),
        .do_write (op_q == OP_WRITE),
        .wdata    (wdata_q),
        .row_q    (row_q)
    );

    sram_rc_col_select #(.WORD_W(WORD_W), .K(WORDS_PER_ROW), .COL_BITS(COL_BITS)) u_colsel (
        .clk      (clk),
        .rst      (rst),
        .col_t    (addr_t[COL_BITS-1:0]),
        .col_c    (addr_c[COL_BITS-1:0]),
        .row_bits (row_q),
        .col_sel  (col_sel),
        .in_range (in_range),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (op_q == OP_READ) begin
            rdata <= rd_word;
        end
    end

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (op_q != OP_READ) |=> $stable(rdata))
        else $error("read data moved without a read");

    assert_oob_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_READ && !in_range) |=> (rdata == '0))
        else $error("out-of-range read returned nonzero");

endmodule

// File: tb/sram_rowcol_array_tb_top.sv
`timescale 1ns/1ps
module sram_rowcol_array_tb_top;

    localparam int WORD_W = 8;
    localparam int ROW_BITS = 3;
    localparam int K = 3;
    localparam int ADDR_W = 5;
    localparam int NADDR = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rdata;

    always #2.5 clk = ~clk;

    sram_rowcol_array #(.WORD_W(WORD_W), .ROW_BITS(ROW_BITS), .WORDS_PER_ROW(K)) dut_i (
        .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference: flat word store plus one pending operation.
    int model_mem [NADDR];
    bit pend_valid = 1'b0;
    bit pend_write = 1'b0;
    int pend_addr = 0;
    int pend_data = 0;
    int exp_rdata = 0;

    function automatic bit in_rng(int a);
        return (a % 4) < K;
    endfunction

    task automatic check(string tag, int act, int expv, string what);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NADDR; i++) model_mem[i] = 0;
        pend_valid = 1'b0;
        exp_rdata = 0;
    endtask

    task automatic cycle(bit e_n, bit w_n, int a, int d, string tag);
        @(negedge clk);
        en_n = e_n; we_n = w_n; addr = a[ADDR_W-1:0]; wdata = d[WORD_W-1:0];
        @(posedge clk);
        #1;
        if (pend_valid) begin
            if (pend_write) begin
                if (in_rng(pend_addr)) model_mem[pend_addr] = pend_data;
            end else begin
                exp_rdata = in_rng(pend_addr) ? model_mem[pend_addr] : 0;
            end
        end
        pend_valid = !e_n;
        pend_write = !w_n;
        pend_addr = a % NADDR;
        pend_data = d & 255;
        check(tag, int'(rdata), exp_rdata, "rdata");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", int'(rdata), 0, "rdata after reset");
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < NADDR; a++) cycle(1'b0, 1'b1, a, 0, in_rng(a) ? tag : "R6");
        cycle(1'b1, 1'b1, 0, 0, "R7");
    endtask

    initial begin
        model_reset();
        // R1: reset state, all words zero
        do_reset();
        read_all("R1");

        // R3 / R6: fill every address; out-of-range writes must vanish
        for (int a = 0; a < NADDR; a++)
            cycle(1'b0, 1'b0, a, in_rng(a) ? ((a * 37 + 5) & 255) : 8'hEE, in_rng(a) ? "R3" : "R6");
        // R4: row/column split, each word distinct
        read_all("R4");

        // R3 / R5: write then read the same word back to back
        cycle(1'b0, 1'b0, 9, 8'h5A, "R3");
        cycle(1'b0, 1'b1, 9, 0, "R5");
        cycle(1'b1, 1'b1, 0, 0, "R5");
        cycle(1'b1, 1'b1, 0, 0, "R7");

        // R5: latency against a different prior value
        cycle(1'b0, 1'b1, 4, 0, "R5");
        cycle(1'b0, 1'b1, 20, 0, "R5");
        cycle(1'b0, 1'b0, 21, 8'hC3, "R7");
        cycle(1'b0, 1'b1, 21, 0, "R7");
        cycle(1'b1, 1'b0, 21, 0, "R8");

        // R8: read captured, then block disabled; R2 / R7: disabled writes ignored
        cycle(1'b0, 1'b1, 1, 0, "R8");
        for (int i = 0; i < 10; i++)
            cycle(1'b1, 1'b0, (i * 7) % NADDR, 8'hFF - i, i == 0 ? "R8" : "R2");
        // R8: write captured, then block disabled, write still lands
        cycle(1'b0, 1'b0, 30, 8'h77, "R8");
        cycle(1'b1, 1'b1, 30, 0, "R8");
        // R2 / R4: read back everything, nothing disturbed
        read_all("R2");

        // R6: out-of-range write into a full row, neighbours unchanged
        cycle(1'b0, 1'b0, 15, 8'h99, "R6");
        cycle(1'b0, 1'b1, 12, 0, "R6");
        cycle(1'b0, 1'b1, 13, 0, "R6");
        cycle(1'b0, 1'b1, 14, 0, "R6");
        cycle(1'b0, 1'b1, 15, 0, "R6");
        cycle(1'b1, 1'b1, 0, 0, "R6");

        // R1: reset mid-run clears contents
        do_reset();
        read_all("R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule